// File: doc/BRIEF.md
# Processor Reset and Strap Sequencer

This block turns a system reset input into the active-low reset that a processor sees, and it also times a bus-request strap line that the processor samples when its reset is released. While the system reset input is high, the processor reset output is held low and the strap is driven low. When the system reset input falls, the processor reset output stays low for a programmable stretch of bus clocks. The default stretch is 200000 cycles, which is about one millisecond at 200 MHz. The reset output then rises.

The strap does not change at the release edge. It stays driven low for a programmable hold count of bus clocks after the release, and then its output-enable drops so that the line floats. If the system reset input returns at any point, the block goes back to its reset state on the next clock edge. Every output comes straight from a flip-flop, so no output can glitch.

The stretch must be larger than 4 cycles, so the strap is set up before the release. The hold count must lie between 2 and 20. A parameter outside either range stops elaboration.

Top module: `rstseq_top`

## Requirements
- R1: At each clock edge where `sys_rst` is 1, the block enters its reset state. In that state `cpu_rst_n` is 0, `strap_oe` is 1 and `strap_n` is 0 after the edge.
- R2: After `sys_rst` falls, `cpu_rst_n` stays 0 until the STRETCH_CYCLES-th rising edge with `sys_rst` low. It becomes 1 after that edge.
- R3: Whenever `cpu_rst_n` is 0, `strap_oe` is 1 and `strap_n` is 0.
- R4: The strap is driven low for at least 4 cycles before `cpu_rst_n` rises. This is guaranteed because STRETCH_CYCLES must exceed 4.
- R5: After `cpu_rst_n` rises, `strap_oe` stays 1 for exactly HOLD_CYCLES cycles, with HOLD_CYCLES between 2 and 20. It then falls to 0.
- R6: If `sys_rst` is raised during the stretch, during the hold window or after the sequence has finished, the block returns to its reset state on the next edge. The full stretch then starts again after `sys_rst` falls.
- R7: Once released, `cpu_rst_n` stays 1 and `strap_oe` stays 0 for as long as `sys_rst` stays 0.
- R8: When `strap_oe` is 0, `strap_n` is 1. When `strap_oe` is 1, `strap_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| sys_rst | input | 1 | System reset input, active-high, sampled synchronously |
| cpu_rst_n | output | 1 | Processor reset, active-low, registered |
| strap_n | output | 1 | Strap drive value, low while the strap is driven |
| strap_oe | output | 1 | Strap output-enable; when 0 the line is released to high impedance |

## Verification
The bench builds the block with STRETCH_CYCLES = 8 and HOLD_CYCLES = 3. With these values a full reset sequence lasts only a few cycles, so each cycle of the stretch, the hold window and the settled state can be compared with counts worked out from the release edge. The short sequence also makes it possible to raise `sys_rst` again at every cycle offset of the sequence. The bench sweeps the pulse width of `sys_rst` as well, and after each restart it confirms that the whole stretch is timed again.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

    // Sequencer phases
    typedef enum logic [1:0] {
        PH_ASSERT,
        PH_STRETCH,
        PH_HOLD,
        PH_RUN
    } phase_e;

    // Registered output pins
    typedef struct packed {
        logic cpu_rst_n;
        logic strap_oe;
        logic strap_n;
    } pins_t;

    localparam int SETUP_MIN = 4;
    localparam int HOLD_MIN  = 2;
    localparam int HOLD_MAX  = 20;

    localparam pins_t PINS_RESET = '{cpu_rst_n: 1'b0, strap_oe: 1'b1, strap_n: 1'b0};

    function automatic int cnt_width(input int a, input int b);
        int m;
        m = (a > b) ? a : b;
        return $clog2(m + 1);
    endfunction

endpackage

// File: rtl/rstseq_downcnt.sv
module rstseq_downcnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         zero
);
    logic [W-1:0] q;

    always_ff @(posedge clk) begin
        if (load)
            q <= load_val;
        else if (dec)
            q <= q - W'(1);
    end

    assign zero = (q == '0);
endmodule

// File: rtl/rstseq_ctrl.sv
module rstseq_ctrl
    import rstseq_pkg::*;
#(
    parameter int STRETCH_CYCLES = 200000,
    parameter int HOLD_CYCLES    = 10,
    parameter int W              = 18
) (
    input  logic         clk,
    input  logic         sys_rst,
    input  logic         cnt_zero,
    output logic         cnt_load,
    output logic [W-1:0] cnt_val,
    output logic         cnt_dec,
    output pins_t        pins
);
    phase_e phase;
    logic   in_stretch;

    assign in_stretch = (phase == PH_ASSERT) || (phase == PH_STRETCH);

    // Counter control: the stretch count loads in reset, the hold count loads at release
    always_comb begin
        cnt_load = sys_rst || (in_stretch && cnt_zero);
        cnt_val  = sys_rst ? W'(STRETCH_CYCLES - 1) : W'(HOLD_CYCLES - 1);
        cnt_dec  = !cnt_load && !cnt_zero;
    end

    always_ff @(posedge clk) begin
        if (sys_rst) begin
            phase <= PH_ASSERT;
            pins  <= PINS_RESET;
        end else begin
            case (phase)
                PH_ASSERT, PH_STRETCH: begin
                    if (cnt_zero) begin
                        phase          <= PH_HOLD;
                        pins.cpu_rst_n <= 1'b1;
                    end else begin
                        phase <= PH_STRETCH;
                    end
                end
                PH_HOLD: begin
                    if (cnt_zero) begin
                        phase         <= PH_RUN;
                        pins.strap_oe <= 1'b0;
                        pins.strap_n  <= 1'b1;
                    end
                end
                default: phase <= PH_RUN;
            endcase
        end
    end

    // Checker state: cycles seen with reset released and strap still driven
    logic [4:0] hold_seen;
    always_ff @(posedge clk) begin
        if (sys_rst)
            hold_seen <= '0;
        else if (pins.cpu_rst_n && pins.strap_oe && hold_seen != 5'd31)
            hold_seen <= hold_seen + 5'd1;
    end

    // R3: the strap is driven low while processor reset is low
    a_r3_strap_in_reset: assert property (@(posedge clk) disable iff (sys_rst)
        !pins.cpu_rst_n |-> (pins.strap_oe && !pins.strap_n));

    // R8: a released strap carries a high drive value
    a_r8_release_value: assert property (@(posedge clk) disable iff (sys_rst)
        !pins.strap_oe |-> pins.strap_n);

    // R7: release is sticky while the system reset stays low
    a_r7_rst_sticky: assert property (@(posedge clk) disable iff (sys_rst)
        pins.cpu_rst_n |=> pins.cpu_rst_n);

    // R7: a released strap stays released
    a_r7_oe_sticky: assert property (@(posedge clk) disable iff (sys_rst)
        !pins.strap_oe |=> !pins.strap_oe);

    // R4: the strap was already driven several cycles before release
    a_r4_setup: assert property (@(posedge clk) disable iff (sys_rst)
        $rose(pins.cpu_rst_n) |-> ($past(pins.strap_oe, 1) && $past(pins.strap_oe, 4)));

    // R5: the strap floats only after exactly the hold count of released cycles
    a_r5_hold_len: assert property (@(posedge clk) disable iff (sys_rst)
        $fell(pins.strap_oe) |-> (pins.cpu_rst_n && hold_seen == 5'(HOLD_CYCLES)));
endmodule

// File: rtl/rstseq_top.sv
module rstseq_top
    import rstseq_pkg::*;
#(
    parameter int STRETCH_CYCLES = 200000,
    parameter int HOLD_CYCLES    = 10
) (
    input  logic clk,
    input  logic sys_rst,
    output logic cpu_rst_n,
    output logic strap_n,
    output logic strap_oe
);
    localparam int W = cnt_width(STRETCH_CYCLES, HOLD_CYCLES);

    // Elaboration checks on the timing parameters
    if (HOLD_CYCLES < HOLD_MIN || HOLD_CYCLES > HOLD_MAX) begin : g_bad_hold
        $error("HOLD_CYCLES out of range");
    end
    if (STRETCH_CYCLES <= SETUP_MIN) begin : g_bad_stretch
        $error("STRETCH_CYCLES must exceed the strap setup");
    end

    logic         cnt_load;
    logic         cnt_dec;
    logic         cnt_zero;
    logic [W-1:0] cnt_val;
    pins_t        pins;

    rstseq_ctrl #(
        .STRETCH_CYCLES(STRETCH_CYCLES),
        .HOLD_CYCLES   (HOLD_CYCLES),
        .W             (W)
    ) u_ctrl (
        .clk     (clk),
        .sys_rst (sys_rst),
        .cnt_zero(cnt_zero),
        .cnt_load(cnt_load),
        .cnt_val (cnt_val),
        .cnt_dec (cnt_dec),
        .pins    (pins)
    );

    rstseq_downcnt #(.W(W)) u_cnt (
        .clk     (clk),
        .load    (cnt_load),
        .load_val(cnt_val),
        .dec     (cnt_dec),
        .zero    (cnt_zero)
    );

    assign cpu_rst_n = pins.cpu_rst_n;
    assign strap_n   = pins.strap_n;
    assign strap_oe  = pins.strap_oe;
endmodule

// File: tb/sim_rstseq_top.sv
module sim_rstseq_top;
    localparam int PERIOD  = 10;
    localparam int STRETCH = 8;
    localparam int HOLD    = 3;
    localparam int SPAN    = STRETCH + HOLD + 4;

    logic clk = 1'b0;
    logic sys_rst = 1'b1;
    logic cpu_rst_n, strap_n, strap_oe;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    rstseq_top #(.STRETCH_CYCLES(STRETCH), .HOLD_CYCLES(HOLD)) u0 (
        .clk(clk), .sys_rst(sys_rst), .cpu_rst_n(cpu_rst_n),
        .strap_n(strap_n), .strap_oe(strap_oe)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // One edge, then sample at the falling edge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // R1: reset state after an edge with sys_rst high
    task automatic check_reset_state(input string tag);
        chk({tag, " R1 cpu_rst_n"}, cpu_rst_n, 1'b0);
        chk({tag, " R1 strap_oe"}, strap_oe, 1'b1);
        chk({tag, " R1 strap_n"}, strap_n, 1'b0);
    endtask

    // Expected pins k edges after sys_rst falls
    task automatic check_k(input int k);
        logic er, eo;
        er = (k >= STRETCH);
        eo = (k < STRETCH + HOLD);
        chk($sformatf("R2 cpu_rst_n k=%0d", k), cpu_rst_n, er);
        chk($sformatf("R5 strap_oe k=%0d", k), strap_oe, eo);
        chk($sformatf("R8 strap_n k=%0d", k), strap_n, ~eo);
        if (!er) chk($sformatf("R3 strap driven k=%0d", k), strap_oe & ~strap_n, 1'b1);
    endtask

    initial begin
        @(negedge clk);
        sys_rst = 1'b1;
        for (int i = 0; i < 3; i++) begin
            step();
            check_reset_state("init");
        end

        // Full sequence, then settled state (R2, R4, R5, R7, R8)
        sys_rst = 1'b0;
        for (int k = 1; k <= SPAN; k++) begin
            step();
            check_k(k);
        end
        for (int k = 0; k < 20; k++) begin
            step();
            chk("R7 cpu_rst_n stays high", cpu_rst_n, 1'b1);
            chk("R7 strap_oe stays low", strap_oe, 1'b0);
        end

        // R4: strap driven at least 4 cycles before release, counted at the pins
        sys_rst = 1'b1;
        step();
        sys_rst = 1'b0;
        begin
            int driven = 0;
            while (cpu_rst_n !== 1'b1) begin
                step();
                if (cpu_rst_n !== 1'b1 && strap_oe === 1'b1) driven++;
            end
            chk("R4 setup >= 4 cycles", (driven >= 4), 1'b1);
        end
        for (int k = 0; k < HOLD + 2; k++) step();

        // R6: reassert at every offset, with several pulse widths
        for (int w = 1; w <= 3; w++) begin
            for (int j = 1; j <= STRETCH + HOLD + 2; j++) begin
                sys_rst = 1'b1;
                step();
                sys_rst = 1'b0;
                for (int k = 1; k <= j; k++) step();
                sys_rst = 1'b1;
                for (int p = 0; p < w; p++) begin
                    step();
                    check_reset_state($sformatf("R6 j=%0d w=%0d", j, w));
                end
                sys_rst = 1'b0;
                for (int k = 1; k <= SPAN; k++) begin
                    step();
                    check_k(k);
                end
            end
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule